// File: doc/BRIEF.md
# Latched Fault Status and Interrupt Request

This block collects live condition flags from a power-output stage: thermal shutdown, undervoltage, overcurrent, output disabled and power not good. It presents them to a bus target as an 8-bit status byte. The byte is frozen between reads. When a status read completes, the byte is refreshed from the live flags, merged with any condition edges that were captured while it was frozen.

The block also drives the enable of an open-drain, active-low interrupt pull-down. The line may be shared with other devices. The interrupt is raised when the supply-ready input first goes high, and when one of the three fault conditions (thermal, undervoltage, overcurrent) shows a rising edge. The output-disabled and power-not-good conditions are reported in the byte but never raise the interrupt. The interrupt is released only when the bus target acknowledges this device's address for a read. Finishing the data transfer does not release it.

Top module: `fault_status_irq`

## Requirements
- R1: After a synchronous reset the status byte is 8'h00 and the interrupt pull-down enable is 0.
- R2: A rising edge on `pwr_ready` sets `irq_pull_en` and status bit 1 (undervoltage) on the next clock edge.
- R3: While `pwr_ready` is high, a rising edge on condition bit 0 (thermal), bit 1 (undervoltage) or bit 2 (overcurrent) sets `irq_pull_en` on the next clock edge.
- R4: Rising edges on condition bit 3 (output disabled) and bit 4 (power not good) never set `irq_pull_en`.
- R5: `irq_pull_en` clears on the clock edge after a `rd_addr_ack` pulse and is cleared by nothing else; `rd_done` has no effect on it.
- R6: If a set cause and `rd_addr_ack` occur in the same cycle, `irq_pull_en` is set.
- R7: The status byte holds its value in every cycle without `rd_done` or a `pwr_ready` rising edge, whatever the live conditions do.
- R8: On the edge after `rd_done`, status bits 4:0 become the live conditions ORed with the captured edges, and the captured edges are cleared.
- R9: A rising edge of any condition seen while `pwr_ready` is high is captured, and it appears in the byte at the next reload even if the live flag has fallen by then.
- R10: A condition held high raises the interrupt once; it raises it again only after it falls and rises again.
- R11: Status bits 7:5 always read 0. Bit 0 is thermal, bit 1 undervoltage, bit 2 overcurrent, bit 3 output disabled and bit 4 power not good.
- R12: The undervoltage bit set at power-up clears at the first reload if live undervoltage is low.
- R13: While `pwr_ready` is low, condition edges neither raise the interrupt nor are captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| live_cond | input | 5 | Live condition flags, bit order as in R11 |
| pwr_ready | input | 1 | Internal supply ready |
| rd_addr_ack | input | 1 | One-cycle pulse: own address acknowledged with read bit set |
| rd_done | input | 1 | One-cycle pulse: status read transfer finished |
| status_byte | output | 8 | Latched status byte |
| irq_pull_en | output | 1 | Enable of the open-drain interrupt pull-down (1 = line low) |

## Verification
The assertions assume that `rd_addr_ack` and `rd_done` are single-cycle pulses, that they are synchronous to `clk`, and that live flags change only between clock edges. The bench drives every input on the falling edge and raises each strobe for exactly one cycle. It changes live flags and strobes in the same cycle only where R6 and the reload merge need that overlap. The supply-ready input is lowered only in the final phase, so that the gating of R13 can be seen apart from power-up.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int unsigned COND_W  = 5;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned IDX_THM = 0;
  localparam int unsigned IDX_UV  = 1;
  localparam int unsigned IDX_OC  = 2;
  localparam int unsigned IDX_OFF = 3;
  localparam int unsigned IDX_PNG = 4;
  localparam logic [COND_W-1:0] IRQ_SRC_MASK =
    (COND_W'(1) << IDX_THM) | (COND_W'(1) << IDX_UV) | (COND_W'(1) << IDX_OC);
endpackage

// File: rtl/fsi_edge_detect.sv
module fsi_edge_detect #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_i;
  end

  assign rise_o = en_i ? (level_i & ~prev_q) : '0;
endmodule

// File: rtl/fsi_irq_ctrl.sv
module fsi_irq_ctrl #(
  parameter int unsigned COND_W = 5,
  parameter logic [COND_W-1:0] SRC_MASK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond_rise_i,
  input  logic              pwr_rise_i,
  input  logic              ack_i,
  output logic              irq_o
);
  logic irq_q;
  logic set_w;

  assign set_w = (|(cond_rise_i & SRC_MASK)) | pwr_rise_i;

  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (set_w) irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  AST_IRQ_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !set_w) |=> !irq_q); // R5
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack_i) |=> irq_q); // R5
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
    (pwr_rise_i && ack_i) |=> irq_q); // R6
endmodule

// File: rtl/fsi_status_latch.sv
module fsi_status_latch #(
  parameter int unsigned COND_W = 5,
  parameter int unsigned STAT_W = 8,
  parameter int unsigned UV_IDX = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] live_i,
  input  logic [COND_W-1:0] rise_i,
  input  logic              reload_i,
  input  logic              pwr_rise_i,
  output logic [STAT_W-1:0] status_o
);
  localparam int unsigned PAD_W = STAT_W - COND_W;

  logic [COND_W-1:0] pend_q;
  logic [COND_W-1:0] stat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      stat_q <= '0;
    end else begin
      if (reload_i) pend_q <= '0;
      else          pend_q <= pend_q | rise_i;
      for (int i = 0; i < COND_W; i++) begin
        if (pwr_rise_i && (i == UV_IDX)) stat_q[i] <= 1'b1;
        else if (reload_i)               stat_q[i] <= live_i[i] | pend_q[i];
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign status_o = {{PAD_W{1'b0}}, stat_q};
    end else begin : g_nopad
      assign status_o = stat_q[STAT_W-1:0];
    end
  endgenerate

  AST_FROZEN_BETWEEN_READS: assert property (@(posedge clk) disable iff (rst)
    (!reload_i && !pwr_rise_i) |=> $stable(stat_q)); // R7
  AST_RELOAD_MERGE: assert property (@(posedge clk) disable iff (rst)
    (reload_i && !pwr_rise_i) |=> (stat_q == $past(live_i | pend_q))); // R8
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
    reload_i |=> (pend_q == '0)); // R8
  AST_UV_AT_POWERUP: assert property (@(posedge clk) disable iff (rst)
    pwr_rise_i |=> stat_q[UV_IDX]); // R2
endmodule

// File: rtl/fault_status_irq.sv
module fault_status_irq
  import fsi_pkg::*;
#(
  parameter int unsigned N_COND  = COND_W,
  parameter int unsigned N_STAT  = STAT_W,
  parameter int unsigned UV_BIT  = IDX_UV,
  parameter logic [N_COND-1:0] IRQ_MASK = IRQ_SRC_MASK
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_COND-1:0] live_cond,
  input  logic              pwr_ready,
  input  logic              rd_addr_ack,
  input  logic              rd_done,
  output logic [N_STAT-1:0] status_byte,
  output logic              irq_pull_en
);
  logic [N_COND-1:0] cond_rise;
  logic              pwr_rise;

  fsi_edge_detect #(.W(N_COND)) u_cond_edge (
    .clk(clk), .rst(rst), .en_i(pwr_ready), .level_i(live_cond), .rise_o(cond_rise)
  );

  fsi_edge_detect #(.W(1)) u_pwr_edge (
    .clk(clk), .rst(rst), .en_i(1'b1), .level_i(pwr_ready), .rise_o(pwr_rise)
  );

  fsi_irq_ctrl #(.COND_W(N_COND), .SRC_MASK(IRQ_MASK)) u_irq (
    .clk(clk), .rst(rst), .cond_rise_i(cond_rise), .pwr_rise_i(pwr_rise),
    .ack_i(rd_addr_ack), .irq_o(irq_pull_en)
  );

  fsi_status_latch #(.COND_W(N_COND), .STAT_W(N_STAT), .UV_IDX(UV_BIT)) u_stat (
    .clk(clk), .rst(rst), .live_i(live_cond), .rise_i(cond_rise),
    .reload_i(rd_done), .pwr_rise_i(pwr_rise), .status_o(status_byte)
  );

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pull_en) |-> $past((|(cond_rise & IRQ_MASK)) | pwr_rise)); // R4
  AST_GATED_WHEN_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
    (!pwr_ready && !irq_pull_en && !pwr_rise) |=> !irq_pull_en); // R13
endmodule

// File: tb/sim_fault_status_irq.sv
module sim_fault_status_irq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] live = '0;
  logic       pwr = 1'b0;
  logic       ack = 1'b0;
  logic       done = 1'b0;
  logic [7:0] status_byte;
  logic       irq_pull_en;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fault_status_irq u0 (
    .clk(clk), .rst(rst), .live_cond(live), .pwr_ready(pwr),
    .rd_addr_ack(ack), .rd_done(done),
    .status_byte(status_byte), .irq_pull_en(irq_pull_en)
  );

  // behavioural reference
  bit [4:0] m_stat, m_pend, m_prev;
  bit       m_irq, m_pwr_prev;

  always @(posedge clk) begin
    bit [4:0] rises;
    bit       pup;
    bit [4:0] ns;
    if (rst) begin
      m_stat = 0; m_pend = 0; m_prev = 0; m_irq = 0; m_pwr_prev = 0;
    end else begin
      rises = pwr ? (live & ~m_prev) : 5'b0;
      pup   = pwr && !m_pwr_prev;
      ns    = done ? (live | m_pend) : m_stat;
      if (pup) ns[1] = 1'b1;
      if (pup || (rises[0] || rises[1] || rises[2])) m_irq = 1'b1;
      else if (ack) m_irq = 1'b0;
      m_pend = done ? 5'b0 : (m_pend | rises);
      m_stat = ns;
      m_prev = live;
      m_pwr_prev = pwr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // advance one cycle with given inputs, then compare against the model
  task automatic cyc(input bit [4:0] l, input bit p, input bit a, input bit d);
    live = l; pwr = p; ack = a; done = d;
    @(negedge clk);
    chk(status_byte == {3'b000, m_stat}, "R8 model status", status_byte, {3'b000, m_stat});
    chk(irq_pull_en == m_irq, "R5 model irq", irq_pull_en, m_irq);
    chk(status_byte[7:5] == 3'b000, "R11 pad bits", status_byte[7:5], 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(status_byte == 8'h00, "R1 reset status", status_byte, 0);
    chk(irq_pull_en == 1'b0, "R1 reset irq", irq_pull_en, 0);

    cyc(5'h00, 1, 0, 0);
    chk(irq_pull_en == 1'b1, "R2 irq at power-up", irq_pull_en, 1);
    chk(status_byte == 8'h02, "R2 uv at power-up", status_byte, 8'h02);
    cyc(5'h00, 1, 0, 0);
    cyc(5'h00, 1, 0, 1);
    chk(irq_pull_en == 1'b1, "R5 rd_done leaves irq", irq_pull_en, 1);
    chk(status_byte == 8'h00, "R12 uv cleared at reload", status_byte, 0);
    cyc(5'h00, 1, 1, 0);
    chk(irq_pull_en == 1'b0, "R5 ack clears irq", irq_pull_en, 0);

    cyc(5'h08, 1, 0, 0);
    chk(irq_pull_en == 1'b0, "R4 disabled bit no irq", irq_pull_en, 0);
    cyc(5'h18, 1, 0, 0);
    chk(irq_pull_en == 1'b0, "R4 pgood bit no irq", irq_pull_en, 0);
    chk(status_byte == 8'h00, "R7 frozen", status_byte, 0);
    cyc(5'h18, 1, 0, 1);
    chk(status_byte == 8'h18, "R8 reload", status_byte, 8'h18);
    cyc(5'h00, 1, 0, 0);

    cyc(5'h01, 1, 0, 0);
    chk(irq_pull_en == 1'b1, "R3 thermal irq", irq_pull_en, 1);
    chk(status_byte == 8'h18, "R7 frozen on fault", status_byte, 8'h18);
    cyc(5'h01, 1, 1, 0);
    chk(irq_pull_en == 1'b0, "R5 ack clears", irq_pull_en, 0);
    for (int i = 0; i < 3; i++) cyc(5'h01, 1, 0, 0);
    chk(irq_pull_en == 1'b0, "R10 held fault no retrigger", irq_pull_en, 0);
    cyc(5'h00, 1, 0, 0);
    cyc(5'h01, 1, 0, 0);
    chk(irq_pull_en == 1'b1, "R10 retrigger after fall", irq_pull_en, 1);
    cyc(5'h01, 1, 1, 0);

    cyc(5'h05, 1, 0, 0);
    chk(irq_pull_en == 1'b1, "R3 overcurrent irq", irq_pull_en, 1);
    cyc(5'h01, 1, 1, 0);
    cyc(5'h01, 1, 0, 1);
    chk(status_byte == 8'h05, "R9 captured pulse", status_byte, 8'h05);
    cyc(5'h00, 1, 0, 1);
    chk(status_byte == 8'h00, "R9 pending cleared", status_byte, 0);

    cyc(5'h02, 1, 1, 0);
    chk(irq_pull_en == 1'b1, "R6 set beats ack", irq_pull_en, 1);
    cyc(5'h00, 1, 1, 0);
    chk(irq_pull_en == 1'b0, "R5 clear after", irq_pull_en, 0);
    cyc(5'h00, 1, 0, 1);

    cyc(5'h00, 0, 0, 0);
    cyc(5'h07, 0, 0, 0);
    chk(irq_pull_en == 1'b0, "R13 no irq unpowered", irq_pull_en, 0);
    cyc(5'h00, 0, 0, 0);
    cyc(5'h00, 0, 0, 1);
    chk(status_byte == 8'h00, "R13 not captured", status_byte, 0);
    cyc(5'h00, 0, 0, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule